// File: doc/BRIEF.md
# Register Rename Status Table

This block is the architectural register file of an out-of-order core that schedules work through reservation stations. Every register either holds a committed value or is marked pending, in which case it records the tag of the station that will produce its next value. Tag zero means "no pending producer". A register is ready exactly when its stored tag is zero.

At issue, two source lookups return each operand either as a ready value or as the producer tag to wait on. In the same cycle the destination register can be renamed to the tag of the newly allocated station. The table also watches the result broadcast bus. A broadcast value lands only in registers whose pending tag still equals the broadcast tag, so older producers that were renamed over can never overwrite newer state. Lookups see the broadcast of the current cycle through a bypass. They do not see a rename made in that cycle, because the sources of an instruction are read before its own destination is renamed.

Top module: `rename_table`

## Requirements
- R1: After reset every register reads as ready (ready=1) with value 0 and tag 0.
- R2: A lookup of a ready register, with no matching broadcast in that cycle, returns ready=1, the stored value and tag 0.
- R3: A lookup of a pending register, with no matching broadcast in that cycle, returns ready=0 and the nonzero producer tag.
- R4: A rename (ren_valid_i=1, nonzero ren_tag_i) makes the named register pending on ren_tag_i from the next cycle.
- R5: A later rename of a pending register replaces its tag. A broadcast of the older tag then leaves that register's value and tag unchanged.
- R6: A valid broadcast (cdb_valid_i=1) writes cdb_value_i into a register pending on cdb_tag_i and makes it ready from the next cycle. With cdb_valid_i=0 nothing changes.
- R7: When a rename and a matching broadcast reach the same register in one cycle, the rename wins and the register stays pending on the new tag.
- R8: A lookup of a register pending on the tag broadcast in that same cycle returns ready=1 with cdb_value_i and tag 0.
- R9: One broadcast updates every register pending on its tag in the same cycle.
- R10: A lookup made in the same cycle as a rename of that register returns the state from before the rename.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| rd_a_idx_i | input | IDX_W | Register index for lookup port A |
| rd_a_ready_o | output | 1 | Port A operand is a value |
| rd_a_value_o | output | DATA_W | Port A value, meaningful when ready |
| rd_a_tag_o | output | TAG_W | Port A producer tag, 0 when ready |
| rd_b_idx_i | input | IDX_W | Register index for lookup port B |
| rd_b_ready_o | output | 1 | Port B operand is a value |
| rd_b_value_o | output | DATA_W | Port B value, meaningful when ready |
| rd_b_tag_o | output | TAG_W | Port B producer tag, 0 when ready |
| ren_valid_i | input | 1 | Rename request this cycle |
| ren_idx_i | input | IDX_W | Destination register to rename |
| ren_tag_i | input | TAG_W | New producer tag, nonzero |
| cdb_valid_i | input | 1 | Result broadcast this cycle |
| cdb_tag_i | input | TAG_W | Tag of the broadcasting producer, nonzero |
| cdb_value_i | input | DATA_W | Broadcast result value |

## Verification
The assertions assume that a valid rename or broadcast never carries tag zero, because tag zero would make a pending register look ready. They also assume that lookup indices stay below the register count. The stimulus table and the directed sequences always use nonzero tags and in-range indices. When the valid bit of a rename or broadcast is low, its other fields still carry nonzero data, so the check shows that the valid bit alone gates the update. Two registers are deliberately renamed to one tag to exercise the multi-register capture.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int unsigned RT_NUM_REGS = 16;
    localparam int unsigned RT_DATA_W   = 32;
    localparam int unsigned RT_TAG_W    = 4;

    // Tag value zero stands for "no producer outstanding".
    function automatic logic tag_pending(input logic [RT_TAG_W-1:0] tag);
        return tag != '0;
    endfunction

endpackage

// File: rtl/rt_entry.sv
module rt_entry
    import rt_pkg::*;
#(
    parameter int unsigned DATA_W = RT_DATA_W,
    parameter int unsigned TAG_W  = RT_TAG_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ren_hit_i,
    input  logic [TAG_W-1:0]  ren_tag_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_value_i,
    output logic [DATA_W-1:0] value_o,
    output logic [TAG_W-1:0]  tag_o
);

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [TAG_W-1:0]  tag;
    } entry_t;

    entry_t st_d, st_q;
    logic   cdb_hit;

    always_comb begin
        st_d    = st_q;
        cdb_hit = cdb_valid_i && (st_q.tag != '0) && (st_q.tag == cdb_tag_i);
        if (ren_hit_i) begin
            // newest producer always takes over the register
            st_d.tag = ren_tag_i;
        end else if (cdb_hit) begin
            st_d.value = cdb_value_i;
            st_d.tag   = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value_o = st_q.value;
    assign tag_o   = st_q.tag;

    a_r4_rename_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ren_hit_i |=> (tag_o == $past(ren_tag_i)));

    a_r6_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cdb_valid_i && tag_o != '0 && tag_o == cdb_tag_i && !ren_hit_i)
        |=> (tag_o == '0 && value_o == $past(cdb_value_i)));

    a_r5_stale_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ren_hit_i && (!cdb_valid_i || tag_o != cdb_tag_i))
        |=> ($stable(value_o) && $stable(tag_o)));

    a_r7_rename_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ren_hit_i && cdb_valid_i && tag_o != '0 && tag_o == cdb_tag_i)
        |=> (tag_o != '0 && $stable(value_o)));

endmodule

// File: rtl/rt_read_port.sv
module rt_read_port
    import rt_pkg::*;
#(
    parameter int unsigned NUM_REGS = RT_NUM_REGS,
    parameter int unsigned DATA_W   = RT_DATA_W,
    parameter int unsigned TAG_W    = RT_TAG_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [DATA_W-1:0] values_i [NUM_REGS],
    input  logic [TAG_W-1:0]  tags_i   [NUM_REGS],
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_value_i,
    output logic              ready_o,
    output logic [DATA_W-1:0] value_o,
    output logic [TAG_W-1:0]  tag_o
);

    logic [DATA_W-1:0] sel_value;
    logic [TAG_W-1:0]  sel_tag;
    logic              bypass;

    always_comb begin
        sel_value = values_i[idx_i];
        sel_tag   = tags_i[idx_i];
        bypass    = cdb_valid_i && (sel_tag != '0) && (sel_tag == cdb_tag_i);
        if (bypass) begin
            ready_o = 1'b1;
            value_o = cdb_value_i;
            tag_o   = '0;
        end else begin
            ready_o = (sel_tag == '0);
            value_o = sel_value;
            tag_o   = sel_tag;
        end
    end

    a_r3_pending_has_tag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> (tag_o != '0 && tag_o == tags_i[idx_i]));

    a_r8_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cdb_valid_i && tags_i[idx_i] != '0 && tags_i[idx_i] == cdb_tag_i)
        |-> (ready_o && value_o == cdb_value_i));

    a_r2_ready_tag_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ready_o |-> (tag_o == '0));

    a_r2_index_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        32'(idx_i) < NUM_REGS);

endmodule

// File: rtl/rename_table.sv
module rename_table
    import rt_pkg::*;
#(
    parameter int unsigned NUM_REGS = RT_NUM_REGS,
    parameter int unsigned DATA_W   = RT_DATA_W,
    parameter int unsigned TAG_W    = RT_TAG_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [IDX_W-1:0]  rd_a_idx_i,
    output logic              rd_a_ready_o,
    output logic [DATA_W-1:0] rd_a_value_o,
    output logic [TAG_W-1:0]  rd_a_tag_o,
    input  logic [IDX_W-1:0]  rd_b_idx_i,
    output logic              rd_b_ready_o,
    output logic [DATA_W-1:0] rd_b_value_o,
    output logic [TAG_W-1:0]  rd_b_tag_o,
    input  logic              ren_valid_i,
    input  logic [IDX_W-1:0]  ren_idx_i,
    input  logic [TAG_W-1:0]  ren_tag_i,
    input  logic              cdb_valid_i,
    input  logic [TAG_W-1:0]  cdb_tag_i,
    input  logic [DATA_W-1:0] cdb_value_i
);

    localparam int unsigned NUM_RD = 2;

    logic [DATA_W-1:0] value_w [NUM_REGS];
    logic [TAG_W-1:0]  tag_w   [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        logic ren_hit;
        assign ren_hit = ren_valid_i && (ren_idx_i == IDX_W'(g));

        rt_entry #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W)
        ) entry_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .ren_hit_i   (ren_hit),
            .ren_tag_i   (ren_tag_i),
            .cdb_valid_i (cdb_valid_i),
            .cdb_tag_i   (cdb_tag_i),
            .cdb_value_i (cdb_value_i),
            .value_o     (value_w[g]),
            .tag_o       (tag_w[g])
        );
    end

    logic [IDX_W-1:0]  rd_idx   [NUM_RD];
    logic              rd_ready [NUM_RD];
    logic [DATA_W-1:0] rd_value [NUM_RD];
    logic [TAG_W-1:0]  rd_tag   [NUM_RD];

    assign rd_idx[0] = rd_a_idx_i;
    assign rd_idx[1] = rd_b_idx_i;

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rt_read_port #(
            .NUM_REGS (NUM_REGS),
            .DATA_W   (DATA_W),
            .TAG_W    (TAG_W)
        ) port_i (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .idx_i       (rd_idx[p]),
            .values_i    (value_w),
            .tags_i      (tag_w),
            .cdb_valid_i (cdb_valid_i),
            .cdb_tag_i   (cdb_tag_i),
            .cdb_value_i (cdb_value_i),
            .ready_o     (rd_ready[p]),
            .value_o     (rd_value[p]),
            .tag_o       (rd_tag[p])
        );
    end

    assign rd_a_ready_o = rd_ready[0];
    assign rd_a_value_o = rd_value[0];
    assign rd_a_tag_o   = rd_tag[0];
    assign rd_b_ready_o = rd_ready[1];
    assign rd_b_value_o = rd_value[1];
    assign rd_b_tag_o   = rd_tag[1];

    // Input contract: tag zero is reserved, so valid traffic never carries it.
    a_r4_ren_tag_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ren_valid_i |-> tag_pending(RT_TAG_W'(ren_tag_i)));

    a_r6_cdb_tag_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cdb_valid_i |-> (cdb_tag_i != '0));

    // R10: a same-cycle rename of the looked-up register is not visible to port A.
    a_r10_read_before_rename: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ren_valid_i && ren_idx_i == rd_a_idx_i && !rd_a_ready_o)
        |-> (rd_a_tag_o == tag_w[rd_a_idx_i]));

endmodule

// File: tb/rename_table_tb.sv
module rename_table_tb_top;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NREG = 16;
    localparam int unsigned DW   = 32;
    localparam int unsigned TW   = 4;
    localparam int unsigned IW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [IW-1:0] ra_idx, rb_idx, ren_idx;
    logic          ra_rdy, rb_rdy;
    logic [DW-1:0] ra_val, rb_val, cdb_val;
    logic [TW-1:0] ra_tag, rb_tag, ren_tag, cdb_tag;
    logic          ren_v, cdb_v;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_table #(.NUM_REGS(NREG), .DATA_W(DW), .TAG_W(TW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .rd_a_idx_i(ra_idx), .rd_a_ready_o(ra_rdy), .rd_a_value_o(ra_val), .rd_a_tag_o(ra_tag),
        .rd_b_idx_i(rb_idx), .rd_b_ready_o(rb_rdy), .rd_b_value_o(rb_val), .rd_b_tag_o(rb_tag),
        .ren_valid_i(ren_v), .ren_idx_i(ren_idx), .ren_tag_i(ren_tag),
        .cdb_valid_i(cdb_v), .cdb_tag_i(cdb_tag), .cdb_value_i(cdb_val)
    );

    typedef struct packed {
        logic [3:0]    req;
        logic          ren_v;
        logic [IW-1:0] ren_idx;
        logic [TW-1:0] ren_tag;
        logic          cdb_v;
        logic [TW-1:0] cdb_tag;
        logic [DW-1:0] cdb_val;
        logic [IW-1:0] ra;
        logic [IW-1:0] rb;
        logic          ea_rdy;
        logic [DW-1:0] ea_val;
        logic [TW-1:0] ea_tag;
        logic          eb_rdy;
        logic [DW-1:0] eb_val;
        logic [TW-1:0] eb_tag;
    } vec_t;

    localparam int NVEC = 11;
    // Reads are checked before the edge that applies the row's rename/broadcast.
    localparam vec_t VEC [NVEC] = '{
        '{4'd1,  1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 32'h0,  4'd1, 4'd2, 1'b1, 32'h0,  4'd0, 1'b1, 32'h0,  4'd0}, // R1
        '{4'd10, 1'b1, 4'd3, 4'd1, 1'b0, 4'd0, 32'h0,  4'd3, 4'd1, 1'b1, 32'h0,  4'd0, 1'b1, 32'h0,  4'd0}, // R10
        '{4'd3,  1'b1, 4'd5, 4'd2, 1'b0, 4'd0, 32'h0,  4'd3, 4'd5, 1'b0, 32'h0,  4'd1, 1'b1, 32'h0,  4'd0}, // R3, R4
        '{4'd4,  1'b1, 4'd3, 4'd3, 1'b0, 4'd0, 32'h0,  4'd3, 4'd5, 1'b0, 32'h0,  4'd1, 1'b0, 32'h0,  4'd2}, // R4
        '{4'd5,  1'b0, 4'd0, 4'd0, 1'b1, 4'd1, 32'h11, 4'd3, 4'd0, 1'b0, 32'h0,  4'd3, 1'b1, 32'h0,  4'd0}, // R5 stale bc
        '{4'd8,  1'b0, 4'd0, 4'd0, 1'b1, 4'd2, 32'h22, 4'd3, 4'd5, 1'b0, 32'h0,  4'd3, 1'b1, 32'h22, 4'd0}, // R5, R8
        '{4'd7,  1'b1, 4'd3, 4'd4, 1'b1, 4'd3, 32'h33, 4'd5, 4'd3, 1'b1, 32'h22, 4'd0, 1'b1, 32'h33, 4'd0}, // R6, R7 setup
        '{4'd7,  1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 32'h0,  4'd3, 4'd5, 1'b0, 32'h0,  4'd4, 1'b1, 32'h22, 4'd0}, // R7
        '{4'd8,  1'b1, 4'd7, 4'd4, 1'b1, 4'd4, 32'h44, 4'd3, 4'd7, 1'b1, 32'h44, 4'd0, 1'b1, 32'h0,  4'd0}, // R8
        '{4'd6,  1'b0, 4'd0, 4'd0, 1'b0, 4'd4, 32'h99, 4'd3, 4'd7, 1'b1, 32'h44, 4'd0, 1'b0, 32'h0,  4'd4}, // R6 invalid bc
        '{4'd6,  1'b0, 4'd0, 4'd0, 1'b0, 4'd0, 32'h0,  4'd7, 4'd3, 1'b0, 32'h0,  4'd4, 1'b1, 32'h44, 4'd0}  // R6, R2
    };

    task automatic check_port(input string req, input string port, input logic rdy,
                              input logic [DW-1:0] val, input logic [TW-1:0] tag,
                              input logic erdy, input logic [DW-1:0] eval,
                              input logic [TW-1:0] etag);
        total++;
        if (rdy !== erdy || tag !== etag || (erdy && val !== eval)) begin
            bad++;
            $display("FAIL %s port %s: got rdy=%0b val=%h tag=%0d, expected rdy=%0b val=%h tag=%0d",
                     req, port, rdy, val, tag, erdy, eval, etag);
        end
    endtask

    task automatic idle_inputs();
        ren_v = 1'b0; ren_idx = '0; ren_tag = 4'd1;
        cdb_v = 1'b0; cdb_tag = 4'd1; cdb_val = '0;
        ra_idx = '0; rb_idx = '0;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            ren_v = VEC[i].ren_v; ren_idx = VEC[i].ren_idx; ren_tag = VEC[i].ren_tag;
            if (!VEC[i].ren_v) ren_tag = 4'd9;
            cdb_v = VEC[i].cdb_v; cdb_tag = VEC[i].cdb_tag; cdb_val = VEC[i].cdb_val;
            if (cdb_tag == '0) cdb_tag = 4'd9;
            ra_idx = VEC[i].ra; rb_idx = VEC[i].rb;
            #1;
            check_port($sformatf("R%0d row %0d", VEC[i].req, i), "A", ra_rdy, ra_val, ra_tag,
                       VEC[i].ea_rdy, VEC[i].ea_val, VEC[i].ea_tag);
            check_port($sformatf("R%0d row %0d", VEC[i].req, i), "B", rb_rdy, rb_val, rb_tag,
                       VEC[i].eb_rdy, VEC[i].eb_val, VEC[i].eb_tag);
            @(negedge clk);
        end

        // R9: two registers pending on one tag are both filled by one broadcast.
        idle_inputs();
        ren_v = 1'b1; ren_idx = 4'd8; ren_tag = 4'd5;
        @(negedge clk);
        ren_idx = 4'd9;
        @(negedge clk);
        ren_v = 1'b0;
        ra_idx = 4'd8; rb_idx = 4'd9;
        #1;
        check_port("R9 pend", "A", ra_rdy, ra_val, ra_tag, 1'b0, '0, 4'd5);
        check_port("R9 pend", "B", rb_rdy, rb_val, rb_tag, 1'b0, '0, 4'd5);
        cdb_v = 1'b1; cdb_tag = 4'd5; cdb_val = 32'h5555_aaaa;
        @(negedge clk);
        cdb_v = 1'b0; cdb_val = 32'h0;
        #1;
        check_port("R9 fill", "A", ra_rdy, ra_val, ra_tag, 1'b1, 32'h5555_aaaa, 4'd0);
        check_port("R9 fill", "B", rb_rdy, rb_val, rb_tag, 1'b1, 32'h5555_aaaa, 4'd0);

        // R2: untouched register still reads its reset value as ready.
        ra_idx = 4'd15; rb_idx = 4'd3;
        #1;
        check_port("R2 idle reg", "A", ra_rdy, ra_val, ra_tag, 1'b1, 32'h0, 4'd0);
        check_port("R2 kept value", "B", rb_rdy, rb_val, rb_tag, 1'b1, 32'h44, 4'd0);

        // R1: reset again clears pending state and values.
        ren_v = 1'b1; ren_idx = 4'd15; ren_tag = 4'd6;
        @(negedge clk);
        ren_v = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_port("R1 re-reset", "A", ra_rdy, ra_val, ra_tag, 1'b1, 32'h0, 4'd0);
        check_port("R1 re-reset", "B", rb_rdy, rb_val, rb_tag, 1'b1, 32'h0, 4'd0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule